// File: doc/BRIEF.md
# Codec Command Slot Interface

This block lets a host read and write the control registers of an external audio codec through the command and status slots of a serial audio frame. The host loads the data slot first. It then loads the address slot, and that write starts the operation. The block decodes the two slots, issues one request on a simple request/done codec port, and follows the progress of the operation in a small flag vector.

For a register read, the block captures the codec's answer in two receive slot registers and updates the flags. The receive address slot echoes the command address with the direction bit cleared. The receive data slot holds the returned word placed in the data field. Only one command can be in flight at a time. Both transmit slots are frozen from the start of a command until the codec reports completion.

Top module: `codec_cmd_slots`

## Requirements
- R1: After reset, `slot_flags` equals 7'b0000111: both transmit-empty flags (bit 0 address, bit 1 data) and the combined empty flag (bit 2) are set. Receive-valid (bit 3 address, bit 4 data) and receive-busy (bit 5 address, bit 6 data) are clear, and `cmd_req` is low.
- R2: When the address slot is written (`slot_wr_sel` = 0) while no command is pending, `cmd_req` is high for exactly one cycle, starting in the cycle after the write. During that cycle `cmd_write` is the inverse of slot bit 19 (0 means a codec write, 1 means a read), and `cmd_addr` carries slot bits 18:12.
- R3: `cmd_wdata` carries bits 19:4 of the data slot, which is written with `slot_wr_sel` = 1.
- R4: Writing the address slot clears flag bit 0, and writing the data slot clears flag bit 1. Flag bit 2 is set exactly when bits 0 and 1 are both set.
- R5: When a read completes (`cmd_done` while pending), the receive address slot (read back with `slot_rd_sel` = 2) holds the address slot value with bit 19 cleared. The receive data slot (`slot_rd_sel` = 3) holds `cmd_rdata` in bits 19:4, with bits 3:0 zero.
- R6: Issuing a read sets both receive-busy flags. Completion of a read clears both busy flags and sets both receive-valid flags. A write command leaves the valid and busy flags unchanged.
- R7: Completion of any command sets both transmit-empty flags.
- R8: A read strobe (`slot_rd_en`) on select 2 clears only the address receive-valid flag, and on select 3 only the data receive-valid flag. Completion in the same cycle takes precedence.
- R9: While a command is pending, writes to either transmit slot are ignored. No request is issued, and the stored slots (read back with select 0 and 1) keep their values.
- R10: `cmd_done` arriving while no command is pending changes no flag and no receive slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_wr_en | input | 1 | Slot register write strobe |
| slot_wr_sel | input | 2 | Write select: 0 address slot, 1 data slot |
| slot_wr_data | input | 20 | Slot write value |
| slot_rd_en | input | 1 | Slot read strobe (clears receive-valid) |
| slot_rd_sel | input | 2 | Read select: 0/1 transmit slots, 2/3 receive slots |
| slot_rd_data | output | 20 | Selected slot value (combinational) |
| slot_flags | output | 7 | Empty, valid and busy flags |
| cmd_req | output | 1 | One-cycle codec request |
| cmd_write | output | 1 | 1 for a codec register write |
| cmd_addr | output | 7 | Codec register address |
| cmd_wdata | output | 16 | Codec write data |
| cmd_done | input | 1 | Codec completion pulse |
| cmd_rdata | input | 16 | Codec read data, valid with cmd_done |

## Verification
A pending flag stuck high shows in the cycle after the next address write, because no request appears and every later command is lost. A pending flag that drops early lets a new write overwrite the slots under an open command, which the per-cycle readback of select 0 and 1 exposes at once. A wrong echo or data placement becomes visible on the first receive-slot read after completion. A flag set or cleared on the wrong event diverges from the reference model in the cycle right after the edge that caused it.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int SLOT_W   = 20;
  localparam int REG_AW   = 7;
  localparam int REG_DW   = 16;
  localparam int RW_BIT   = 19;
  localparam int ADDR_LSB = 12;
  localparam int DATA_LSB = 4;
  localparam int SEL_W    = 2;
  localparam int NUM_TX   = 2;
  localparam int NUM_RX   = 2;
  localparam int FLAG_W   = 3 + NUM_RX + NUM_RX;

  // slot index order is the select encoding
  localparam int SLOT_ADDR = 0;
  localparam int SLOT_DATA = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADDR_TX = 2'd0,
    SEL_DATA_TX = 2'd1,
    SEL_ADDR_RX = 2'd2,
    SEL_DATA_RX = 2'd3
  } slot_sel_e;

  function automatic logic slot_is_read(input logic [SLOT_W-1:0] s);
    return s[RW_BIT];
  endfunction

  function automatic logic [REG_AW-1:0] slot_reg_addr(input logic [SLOT_W-1:0] s);
    return s[ADDR_LSB +: REG_AW];
  endfunction

  function automatic logic [REG_DW-1:0] slot_wdata(input logic [SLOT_W-1:0] s);
    return s[DATA_LSB +: REG_DW];
  endfunction

  function automatic logic [SLOT_W-1:0] echo_addr(input logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] r;
    r = s;
    r[RW_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [SLOT_W-1:0] pack_rdata(input logic [REG_DW-1:0] d);
    logic [SLOT_W-1:0] r;
    r = '0;
    r[DATA_LSB +: REG_DW] = d;
    return r;
  endfunction
endpackage

// File: rtl/ccs_tx_slots.sv
module ccs_tx_slots
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SLOT_W-1:0] wr_data,
  input  logic              cmd_done,
  output logic [SLOT_W-1:0] addr_slot,
  output logic [SLOT_W-1:0] data_slot,
  output logic              pending,
  output logic              launch,
  output logic              launch_read,
  output logic              finish,
  output logic              cmd_req,
  output logic [NUM_TX-1:0] tx_empty
);
  logic [NUM_TX-1:0] take;
  logic [SLOT_W-1:0] slot_q [NUM_TX];

  assign launch      = take[SLOT_ADDR];
  assign launch_read = launch && slot_is_read(wr_data);
  assign finish      = cmd_done && pending;
  assign addr_slot   = slot_q[SLOT_ADDR];
  assign data_slot   = slot_q[SLOT_DATA];

  for (genvar g = 0; g < NUM_TX; g++) begin : g_slot
    assign take[g] = wr_en && !pending && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g]   <= '0;
        tx_empty[g] <= 1'b1;
      end else begin
        if (take[g]) slot_q[g] <= wr_data;
        if (finish) tx_empty[g] <= 1'b1;
        else if (take[g]) tx_empty[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cmd_req <= 1'b0;
    end else begin
      cmd_req <= launch;
      if (finish) pending <= 1'b0;
      else if (launch) pending <= 1'b1;
    end
  end

  // R2: request is a single-cycle pulse
  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);
  // R2: a request always belongs to an open command
  assert_req_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> pending);
  // R9: slots frozen while a command is open
  assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> ($stable(addr_slot) && $stable(data_slot)));
  // R7: completion marks both slots empty
  assert_empty_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (&tx_empty));
endmodule

// File: rtl/ccs_rx_slots.sv
module ccs_rx_slots
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_read,
  input  logic              finish,
  input  logic [SLOT_W-1:0] addr_slot,
  input  logic [REG_DW-1:0] cmd_rdata,
  input  logic [NUM_RX-1:0] rd_clr,
  output logic [SLOT_W-1:0] rx_addr,
  output logic [SLOT_W-1:0] rx_data,
  output logic [NUM_RX-1:0] rx_valid,
  output logic [NUM_RX-1:0] rx_busy
);
  logic capture;

  assign capture = finish && slot_is_read(addr_slot);

  for (genvar g = 0; g < NUM_RX; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_valid[g] <= 1'b0;
        rx_busy[g]  <= 1'b0;
      end else begin
        if (capture) rx_valid[g] <= 1'b1;
        else if (rd_clr[g]) rx_valid[g] <= 1'b0;
        if (capture) rx_busy[g] <= 1'b0;
        else if (launch_read) rx_busy[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_addr <= '0;
      rx_data <= '0;
    end else if (capture) begin
      rx_addr <= echo_addr(addr_slot);
      rx_data <= pack_rdata(cmd_rdata);
    end
  end

  // R6: both busy flags move together
  assert_busy_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy[0] == rx_busy[1]);
  // R6: a finished read leaves valid set and busy clear
  assert_read_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ((&rx_valid) && !(|rx_busy)));
  // R5: echoed address never carries the direction bit
  assert_echo_rw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_addr[RW_BIT]);
  // R5: low nibble of returned data is zero
  assert_rx_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data[DATA_LSB-1:0] == '0);
endmodule

// File: rtl/codec_cmd_slots.sv
module codec_cmd_slots
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_wr_en,
  input  logic [SEL_W-1:0]  slot_wr_sel,
  input  logic [SLOT_W-1:0] slot_wr_data,
  input  logic              slot_rd_en,
  input  logic [SEL_W-1:0]  slot_rd_sel,
  output logic [SLOT_W-1:0] slot_rd_data,
  output logic [FLAG_W-1:0] slot_flags,
  output logic              cmd_req,
  output logic              cmd_write,
  output logic [REG_AW-1:0] cmd_addr,
  output logic [REG_DW-1:0] cmd_wdata,
  input  logic              cmd_done,
  input  logic [REG_DW-1:0] cmd_rdata
);
  logic [SLOT_W-1:0] addr_slot, data_slot, rx_addr, rx_data;
  logic              pending, launch, launch_read, finish;
  logic [NUM_TX-1:0] tx_empty;
  logic [NUM_RX-1:0] rx_valid, rx_busy, rd_clr;

  assign rd_clr[0] = slot_rd_en && (slot_rd_sel == SEL_ADDR_RX);
  assign rd_clr[1] = slot_rd_en && (slot_rd_sel == SEL_DATA_RX);

  ccs_tx_slots u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (slot_wr_en),
    .wr_sel      (slot_wr_sel),
    .wr_data     (slot_wr_data),
    .cmd_done    (cmd_done),
    .addr_slot   (addr_slot),
    .data_slot   (data_slot),
    .pending     (pending),
    .launch      (launch),
    .launch_read (launch_read),
    .finish      (finish),
    .cmd_req     (cmd_req),
    .tx_empty    (tx_empty)
  );

  ccs_rx_slots u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_read (launch_read),
    .finish      (finish),
    .addr_slot   (addr_slot),
    .cmd_rdata   (cmd_rdata),
    .rd_clr      (rd_clr),
    .rx_addr     (rx_addr),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_busy     (rx_busy)
  );

  assign cmd_write = !slot_is_read(addr_slot);
  assign cmd_addr  = slot_reg_addr(addr_slot);
  assign cmd_wdata = slot_wdata(data_slot);

  assign slot_flags = {rx_busy, rx_valid, &tx_empty, tx_empty};

  always_comb begin
    unique case (slot_sel_e'(slot_rd_sel))
      SEL_ADDR_TX: slot_rd_data = addr_slot;
      SEL_DATA_TX: slot_rd_data = data_slot;
      SEL_ADDR_RX: slot_rd_data = rx_addr;
      default:     slot_rd_data = rx_data;
    endcase
  end

  // R2: a request appears only after an accepted address write
  assert_req_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> $past(slot_wr_en && slot_wr_sel == SEL_ADDR_TX));
  // R10: completion while idle leaves receive state untouched
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !pending && !slot_rd_en) |=> ($stable(slot_flags) && $stable(rx_data)));
endmodule

// File: tb/test_codec_cmd_slots.sv
module test_codec_cmd_slots;
  import ccs_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              slot_wr_en = 1'b0, slot_rd_en = 1'b0, cmd_done = 1'b0;
  logic [1:0]        slot_wr_sel = '0, slot_rd_sel = '0;
  logic [19:0]       slot_wr_data = '0;
  logic [19:0]       slot_rd_data;
  logic [6:0]        slot_flags;
  logic              cmd_req, cmd_write;
  logic [6:0]        cmd_addr;
  logic [15:0]       cmd_wdata;
  logic [15:0]       cmd_rdata = '0;

  codec_cmd_slots i_codec_cmd_slots (.*);

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, stray = 0, done_run = 0;
  int lat = 2, cd = -1;
  logic [15:0] nxt_rd = '0;

  // behavioural reference
  logic [19:0] m_atx, m_dtx, m_arx, m_drx;
  bit m_ae, m_de, m_av, m_dv, m_ab, m_db, m_pend, m_req;

  always @(posedge clk) begin
    bit was_pend;
    if (!rst_n) begin
      m_atx = 0; m_dtx = 0; m_arx = 0; m_drx = 0;
      m_ae = 1; m_de = 1; m_av = 0; m_dv = 0; m_ab = 0; m_db = 0;
      m_pend = 0; m_req = 0;
    end else begin
      was_pend = m_pend;
      m_req = 0;
      if (slot_rd_en && slot_rd_sel == 2) m_av = 0;
      if (slot_rd_en && slot_rd_sel == 3) m_dv = 0;
      if (cmd_done && was_pend) begin
        m_pend = 0; m_ae = 1; m_de = 1;
        if (m_atx[19]) begin
          m_arx = m_atx & 20'h7FFFF;
          m_drx = {cmd_rdata, 4'h0};
          m_av = 1; m_dv = 1; m_ab = 0; m_db = 0;
        end
      end
      if (slot_wr_en && !was_pend) begin
        if (slot_wr_sel == 0) begin
          m_atx = slot_wr_data; m_ae = 0; m_pend = 1; m_req = 1;
          if (slot_wr_data[19]) begin m_ab = 1; m_db = 1; end
        end else if (slot_wr_sel == 1) begin
          m_dtx = slot_wr_data; m_de = 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [19:0] e;
    chk("R4", 32'(slot_flags[2:0]), 32'({m_ae & m_de, m_de, m_ae}));
    chk("R6", 32'(slot_flags[6:3]), 32'({m_db, m_ab, m_dv, m_av}));
    chk("R2", 32'(cmd_req), 32'(m_req));
    if (m_req) begin
      chk("R2", 32'(cmd_write), 32'(!m_atx[19]));
      chk("R2", 32'(cmd_addr), 32'(m_atx[18:12]));
      chk("R3", 32'(cmd_wdata), 32'(m_dtx[19:4]));
    end
    case (slot_rd_sel)
      2'd0: e = m_atx;
      2'd1: e = m_dtx;
      2'd2: e = m_arx;
      default: e = m_drx;
    endcase
    chk(slot_rd_sel[1] ? "R5" : "R9", 32'(slot_rd_data), 32'(e));
  endtask

  task automatic cyc(bit we, logic [1:0] ws, logic [19:0] wd, bit re, logic [1:0] rs);
    @(negedge clk);
    if (cmp_on) compare();
    slot_wr_en = we; slot_wr_sel = ws; slot_wr_data = wd;
    slot_rd_en = re; slot_rd_sel = rs;
    cmd_done = 0;
    if (cd == 0) begin
      cmd_done = 1; cmd_rdata = nxt_rd; cd = -1;
    end else if (cd > 0) cd--;
    if (cmd_req) cd = lat - 1;
    if (stray) begin cmd_done = 1; cmd_rdata = 16'hDEAD; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic expect_rd(logic [1:0] sel, logic [19:0] exp, string tag);
    cyc(0, 0, 0, 0, sel);
    #1;
    chk(tag, 32'(slot_rd_data), 32'(exp));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [6:0] snap;
    idle(3);
    @(negedge clk); rst_n = 1'b1; cmp_on = 1;
    // R1 reset state
    chk("R1", 32'(slot_flags), 32'h07);
    chk("R1", 32'(cmd_req), 0);

    // R3 / R4: data slot write
    cyc(1, 1, 20'hABCD0, 0, 0);
    idle(1);
    chk("R4", 32'(slot_flags[2:0]), 32'b001);
    // R2: write command
    lat = 2;
    cyc(1, 0, 20'h2A000, 0, 0);
    idle(1);
    chk("R2", 32'(cmd_req), 1);
    chk("R2", 32'(cmd_write), 1);
    chk("R2", 32'(cmd_addr), 32'h2A);
    chk("R3", 32'(cmd_wdata), 32'hABCD);
    chk("R4", 32'(slot_flags[0]), 0);
    idle(4);
    chk("R7", 32'(slot_flags[2:0]), 32'b111);
    chk("R6", 32'(slot_flags[6:3]), 0);

    // R5 / R6: read command
    nxt_rd = 16'h1234;
    cyc(1, 0, 20'h95000, 0, 0);
    idle(1);
    chk("R6", 32'(slot_flags[6:5]), 32'b11);
    chk("R2", 32'(cmd_write), 0);
    chk("R2", 32'(cmd_addr), 32'h15);
    idle(4);
    chk("R6", 32'(slot_flags[6:3]), 32'b0011);
    expect_rd(2, 20'h15000, "R5");
    expect_rd(3, 20'h12340, "R5");

    // R8: clear address valid only
    cyc(0, 0, 0, 1, 2);
    idle(1);
    chk("R8", 32'(slot_flags[4:3]), 32'b10);

    // R9: writes during a pending command
    lat = 6; nxt_rd = 16'hBEEF;
    cyc(1, 1, 20'h11110, 0, 0);
    cyc(1, 0, 20'hB3000, 0, 0);
    idle(1);
    cyc(1, 0, 20'h22000, 0, 0);
    cyc(1, 1, 20'h55550, 0, 0);
    idle(1);
    chk("R9", 32'(cmd_req), 0);
    expect_rd(0, 20'hB3000, "R9");
    expect_rd(1, 20'h11110, "R9");
    idle(6);
    expect_rd(3, 20'hBEEF0, "R5");

    // R10: stray completion while idle
    idle(2);
    snap = slot_flags;
    stray = 1; cyc(0, 0, 0, 0, 3); stray = 0;
    idle(1);
    chk("R10", 32'(slot_flags), 32'(snap));
    chk("R10", 32'(cmd_req), 0);
    expect_rd(3, 20'hBEEF0, "R10");

    // mixed traffic against the reference
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom % 8);
      lat = 1 + int'($urandom % 4);
      nxt_rd = 16'($urandom);
      cyc(r < 4, 2'(r % 2), 20'($urandom), r >= 5, 2'($urandom));
    end
    idle(8);
    done_run = 1;
    finish_run();
  end
endmodule